// File: doc/BRIEF.md
# Priority Transmit Mailbox Arbiter

This block holds a small set of transmit mailboxes and decides which one goes to the bus next. Software fills a mailbox with an identifier, a payload, a length code, a remote flag and a 4-bit urgency value. It then raises that mailbox's send request. From that point the mailbox is pending and its ready flag is low. When the arbiter is between frames, it picks the most urgent pending mailbox. A lower urgency value is more urgent, and on a tie the lower mailbox index wins. It then offers that mailbox's frame to a bus-side transmitter.

The transmitter answers with a one-cycle `tx_done` pulse for a successful send or a one-cycle `tx_fail` pulse for a failed one. Either answer makes the mailbox ready again, and a failure also sets its abort flag. A pending mailbox that has not yet been handed over can be withdrawn with an abort request. Each mailbox's completion interrupt is its ready flag gated by a mask bit.

The controller has two states:
- `ST_IDLE`: between frames; the arbiter chooses here.
- `ST_SEND`: a frame is being offered; `tx_valid` is high.

It has two transitions:
- *take*: `ST_IDLE` to `ST_SEND`, when any mailbox is pending. The winner is latched and its pending state is cleared.
- *finish*: `ST_SEND` to `ST_IDLE`, on `tx_done` or `tx_fail`.

Top module: `txmb_arbiter`

## Requirements
- R1: After reset every mailbox has ready = 1 and abort = 0, and `tx_valid` is 0.
- R2: Among pending mailboxes, the one with the numerically smallest urgency value (0 best, 15 worst) is offered first.
- R3: Pending mailboxes with equal urgency are offered in increasing index order.
- R4: A send request on a ready mailbox makes it pending: its ready bit reads 0 and its abort bit reads 0 from the next cycle. A send request on a mailbox whose ready bit is 0 has no effect.
- R5: While `tx_valid` is high and no response arrives, `tx_valid`, `tx_mb` and the frame fields stay unchanged. A more urgent mailbox made pending in that time does not replace the frame on offer.
- R6: A `tx_done` pulse while a frame is offered sets that mailbox's ready bit to 1 and its abort bit to 0 in the next cycle.
- R7: A `tx_fail` pulse while a frame is offered sets that mailbox's ready bit to 1 and its abort bit to 1 in the next cycle.
- R8: An abort request on a pending mailbox that has not been handed over sets its ready bit and abort bit to 1, and the mailbox is never offered. An abort request on the mailbox currently on offer has no effect.
- R9: A load into a mailbox whose ready bit is 0 is ignored: the identifier and urgency it later transmits with are the ones loaded while it was ready.
- R10: `irq_vec[i]` equals `mb_ready[i] & irq_mask[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load strobe for one mailbox |
| ld_idx | input | IDX_W | Mailbox index to load |
| ld_prio | input | PRIO_W | Urgency value, 0 most urgent |
| ld_id | input | ID_W | Frame identifier |
| ld_len | input | LEN_W | Length code |
| ld_rtr | input | 1 | Remote frame flag |
| ld_data | input | DATA_W | Payload |
| send_req | input | N_MB | Per-mailbox send request |
| abort_req | input | N_MB | Per-mailbox abort request |
| irq_mask | input | N_MB | Per-mailbox interrupt enable |
| tx_valid | output | 1 | Frame offered to the transmitter |
| tx_mb | output | IDX_W | Index of the offered mailbox |
| tx_id | output | ID_W | Offered identifier |
| tx_len | output | LEN_W | Offered length code |
| tx_rtr | output | 1 | Offered remote flag |
| tx_data | output | DATA_W | Offered payload |
| tx_done | input | 1 | Transmitter reports success |
| tx_fail | input | 1 | Transmitter reports failure |
| mb_ready | output | N_MB | Per-mailbox ready flag |
| mb_abort | output | N_MB | Per-mailbox abort flag |
| irq_vec | output | N_MB | Per-mailbox completion interrupt |

## Verification
The selection logic is exercised with four stimulus patterns:
- **Distinct urgency values.** All four mailboxes carry different values. This separates comparison by urgency from comparison by index.
- **Equal urgency values.** All four mailboxes carry the same value. This isolates the tie-break.
- **Late urgent request.** A very urgent request arrives while a low-urgency frame is already on offer. This tells a between-frames decision apart from pre-emption.
- **Busy-mailbox stimulus.** Abort, reload and repeat-send requests are aimed at mailboxes that are pending or on offer. This shows which of those requests take effect and which are ignored.

Success and failure responses are both applied, so the abort flag's two outcomes can be told apart. The interrupt mask is checked against a mix of ready and busy mailboxes.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } arb_state_e;
endpackage

// File: rtl/txmb_pick.sv
module txmb_pick #(
    parameter int N_MB   = 4,
    parameter int PRIO_W = 4,
    localparam int IDX_W = $clog2(N_MB)
) (
    input  logic [N_MB-1:0]             pend,
    input  logic [N_MB-1:0][PRIO_W-1:0] prio,
    output logic                        any,
    output logic [IDX_W-1:0]            idx
);
    logic [PRIO_W-1:0] best;

    // Strict less-than: an equal value later in the scan never displaces an earlier index.
    always_comb begin
        any  = 1'b0;
        idx  = '0;
        best = '1;
        for (int i = 0; i < N_MB; i++) begin
            if (pend[i] && (!any || prio[i] < best)) begin
                any  = 1'b1;
                best = prio[i];
                idx  = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/txmb_store.sv
module txmb_store #(
    parameter int N_MB   = 4,
    parameter int PRIO_W = 4,
    parameter int ID_W   = 29,
    parameter int LEN_W  = 4,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(N_MB)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ld_en,
    input  logic [IDX_W-1:0]            ld_idx,
    input  logic [PRIO_W-1:0]           ld_prio,
    input  logic [ID_W-1:0]             ld_id,
    input  logic [LEN_W-1:0]            ld_len,
    input  logic                        ld_rtr,
    input  logic [DATA_W-1:0]           ld_data,
    input  logic [N_MB-1:0]             send_req,
    input  logic [N_MB-1:0]             abort_req,
    input  logic                        take,
    input  logic [IDX_W-1:0]            take_idx,
    input  logic                        fin,
    input  logic                        fin_fail,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [N_MB-1:0]             pend,
    output logic [N_MB-1:0]             ready,
    output logic [N_MB-1:0]             abrt,
    output logic [N_MB-1:0][PRIO_W-1:0] prio,
    output logic [ID_W-1:0]             rd_id,
    output logic [LEN_W-1:0]            rd_len,
    output logic                        rd_rtr,
    output logic [DATA_W-1:0]           rd_data
);
    logic [ID_W-1:0]   id_q   [N_MB];
    logic [LEN_W-1:0]  len_q  [N_MB];
    logic [DATA_W-1:0] data_q [N_MB];
    logic [N_MB-1:0]   rtr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend  <= '0;
            ready <= '1;
            abrt  <= '0;
            prio  <= '0;
            rtr_q <= '0;
            for (int i = 0; i < N_MB; i++) begin
                id_q[i]   <= '0;
                len_q[i]  <= '0;
                data_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < N_MB; i++) begin
                if (ld_en && ld_idx == IDX_W'(i) && ready[i]) begin
                    id_q[i]   <= ld_id;
                    len_q[i]  <= ld_len;
                    data_q[i] <= ld_data;
                    rtr_q[i]  <= ld_rtr;
                    prio[i]   <= ld_prio;
                end
                if (take && take_idx == IDX_W'(i)) begin
                    pend[i] <= 1'b0;
                end else if (abort_req[i] && pend[i]) begin
                    pend[i]  <= 1'b0;
                    ready[i] <= 1'b1;
                    abrt[i]  <= 1'b1;
                end else if (send_req[i] && ready[i]) begin
                    pend[i]  <= 1'b1;
                    ready[i] <= 1'b0;
                    abrt[i]  <= 1'b0;
                end
                if (fin && rd_idx == IDX_W'(i)) begin
                    ready[i] <= 1'b1;
                    abrt[i]  <= fin_fail;
                end
            end
        end
    end

    assign rd_id   = id_q[rd_idx];
    assign rd_len  = len_q[rd_idx];
    assign rd_data = data_q[rd_idx];
    assign rd_rtr  = rtr_q[rd_idx];
endmodule

// File: rtl/txmb_ctrl.sv
module txmb_ctrl
    import txmb_pkg::*;
#(
    parameter int N_MB   = 4,
    localparam int IDX_W = $clog2(N_MB)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_pend,
    input  logic [IDX_W-1:0] pick_idx,
    input  logic             tx_done,
    input  logic             tx_fail,
    output logic             take,
    output logic             fin,
    output logic             fin_fail,
    output logic             tx_valid,
    output logic [IDX_W-1:0] cur_idx
);
    arb_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cur_idx <= '0;
        end else begin
            state <= state_nx;
            if (take) cur_idx <= pick_idx;
        end
    end

    always_comb begin
        state_nx = state;
        take     = 1'b0;
        fin      = 1'b0;
        fin_fail = 1'b0;
        tx_valid = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (any_pend) begin
                    take     = 1'b1;
                    state_nx = ST_SEND;
                end
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                if (tx_done || tx_fail) begin
                    fin      = 1'b1;
                    fin_fail = tx_fail && !tx_done;
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/txmb_arbiter.sv
module txmb_arbiter #(
    parameter int N_MB   = 4,
    parameter int PRIO_W = 4,
    parameter int ID_W   = 29,
    parameter int LEN_W  = 4,
    parameter int DATA_W = 64,
    localparam int IDX_W = $clog2(N_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [PRIO_W-1:0] ld_prio,
    input  logic [ID_W-1:0]   ld_id,
    input  logic [LEN_W-1:0]  ld_len,
    input  logic              ld_rtr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [N_MB-1:0]   send_req,
    input  logic [N_MB-1:0]   abort_req,
    input  logic [N_MB-1:0]   irq_mask,
    output logic              tx_valid,
    output logic [IDX_W-1:0]  tx_mb,
    output logic [ID_W-1:0]   tx_id,
    output logic [LEN_W-1:0]  tx_len,
    output logic              tx_rtr,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_done,
    input  logic              tx_fail,
    output logic [N_MB-1:0]   mb_ready,
    output logic [N_MB-1:0]   mb_abort,
    output logic [N_MB-1:0]   irq_vec
);
    logic [N_MB-1:0]             pend;
    logic [N_MB-1:0][PRIO_W-1:0] prio;
    logic                        any_pend, take, fin, fin_fail;
    logic [IDX_W-1:0]            pick_idx, cur_idx;

    txmb_pick #(.N_MB(N_MB), .PRIO_W(PRIO_W)) u_pick (
        .pend(pend), .prio(prio), .any(any_pend), .idx(pick_idx)
    );

    txmb_ctrl #(.N_MB(N_MB)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .any_pend(any_pend), .pick_idx(pick_idx),
        .tx_done(tx_done), .tx_fail(tx_fail), .take(take), .fin(fin),
        .fin_fail(fin_fail), .tx_valid(tx_valid), .cur_idx(cur_idx)
    );

    txmb_store #(
        .N_MB(N_MB), .PRIO_W(PRIO_W), .ID_W(ID_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_prio(ld_prio),
        .ld_id(ld_id), .ld_len(ld_len), .ld_rtr(ld_rtr), .ld_data(ld_data),
        .send_req(send_req), .abort_req(abort_req), .take(take), .take_idx(pick_idx),
        .fin(fin), .fin_fail(fin_fail), .rd_idx(cur_idx), .pend(pend),
        .ready(mb_ready), .abrt(mb_abort), .prio(prio), .rd_id(tx_id),
        .rd_len(tx_len), .rd_rtr(tx_rtr), .rd_data(tx_data)
    );

    assign tx_mb   = cur_idx;
    assign irq_vec = mb_ready & irq_mask;
endmodule

// File: rtl/txmb_arbiter_chk.sv
module txmb_arbiter_chk #(
    parameter int N_MB  = 4,
    parameter int IDX_W = 2,
    parameter int ID_W  = 29
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic [IDX_W-1:0] tx_mb,
    input logic [ID_W-1:0]  tx_id,
    input logic             tx_done,
    input logic             tx_fail,
    input logic [N_MB-1:0]  mb_ready,
    input logic [N_MB-1:0]  mb_abort
);
    a_r5_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_done && !tx_fail |=> tx_valid && $stable(tx_mb) && $stable(tx_id));

    a_r6_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_done |=> mb_ready[$past(tx_mb)] && !mb_abort[$past(tx_mb)]);

    a_r7_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && tx_fail && !tx_done |=> mb_ready[$past(tx_mb)] && mb_abort[$past(tx_mb)]);

    a_r4_offer_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !mb_ready[tx_mb] && !mb_abort[tx_mb]);
endmodule

bind txmb_arbiter txmb_arbiter_chk #(.N_MB(N_MB), .IDX_W(IDX_W), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_mb(tx_mb), .tx_id(tx_id),
    .tx_done(tx_done), .tx_fail(tx_fail), .mb_ready(mb_ready), .mb_abort(mb_abort)
);

// File: tb/txmb_arbiter_test.sv
module txmb_arbiter_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [3:0]  ld_prio = '0;
    logic [28:0] ld_id = '0;
    logic [3:0]  ld_len = '0;
    logic        ld_rtr = 1'b0;
    logic [63:0] ld_data = '0;
    logic [3:0]  send_req = '0, abort_req = '0, irq_mask = '0;
    logic        tx_valid, tx_rtr;
    logic [1:0]  tx_mb;
    logic [28:0] tx_id;
    logic [3:0]  tx_len;
    logic [63:0] tx_data;
    logic        tx_done = 1'b0, tx_fail = 1'b0;
    logic [3:0]  mb_ready, mb_abort, irq_vec;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    txmb_arbiter uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_prio(ld_prio),
        .ld_id(ld_id), .ld_len(ld_len), .ld_rtr(ld_rtr), .ld_data(ld_data),
        .send_req(send_req), .abort_req(abort_req), .irq_mask(irq_mask),
        .tx_valid(tx_valid), .tx_mb(tx_mb), .tx_id(tx_id), .tx_len(tx_len),
        .tx_rtr(tx_rtr), .tx_data(tx_data), .tx_done(tx_done), .tx_fail(tx_fail),
        .mb_ready(mb_ready), .mb_abort(mb_abort), .irq_vec(irq_vec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load_mb(input int idx, input int pr, input logic [28:0] id);
        ld_en = 1'b1; ld_idx = 2'(idx); ld_prio = 4'(pr); ld_id = id;
        ld_len = 4'(idx + 1); ld_rtr = idx[0]; ld_data = {35'd0, id};
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic fire(input logic [3:0] m);
        send_req = m;
        @(negedge clk);
        send_req = '0;
    endtask

    task automatic expect_tx(input int mb, input logic [28:0] id, input string req);
        for (int n = 0; n < 20; n++) begin
            if (tx_valid) break;
            @(negedge clk);
        end
        chk(tx_valid, req, "tx_valid", 64'(tx_valid), 64'd1);
        chk(tx_mb == 2'(mb), req, "tx_mb", 64'(tx_mb), 64'(mb));
        chk(tx_id == id, req, "tx_id", 64'(tx_id), 64'(id));
    endtask

    task automatic respond(input bit fail);
        tx_done = !fail; tx_fail = fail;
        @(negedge clk);
        tx_done = 1'b0; tx_fail = 1'b0;
    endtask

    task automatic t_reset;
        irq_mask = 4'hF;
        @(negedge clk);
        chk(mb_ready == 4'hF, "R1", "ready", 64'(mb_ready), 64'hF);
        chk(mb_abort == 4'h0, "R1", "abort", 64'(mb_abort), 64'h0);
        chk(!tx_valid, "R1", "tx_valid", 64'(tx_valid), 64'h0);
        chk(irq_vec == 4'hF, "R10", "irq all", 64'(irq_vec), 64'hF);
    endtask

    task automatic t_prio;
        load_mb(0, 9, 29'h100); load_mb(1, 3, 29'h101);
        load_mb(2, 12, 29'h102); load_mb(3, 7, 29'h103);
        fire(4'hF);
        chk(mb_ready == 4'h0, "R4", "ready after send", 64'(mb_ready), 64'h0);
        expect_tx(1, 29'h101, "R2");
        respond(1'b0);
        chk(mb_ready[1] && !mb_abort[1], "R6", "mb1 done", 64'({mb_ready[1], mb_abort[1]}), 64'h2);
        expect_tx(3, 29'h103, "R2");
        respond(1'b0);
        expect_tx(0, 29'h100, "R2");
        respond(1'b0);
        expect_tx(2, 29'h102, "R2");
        respond(1'b0);
        chk(mb_ready == 4'hF && mb_abort == 4'h0, "R6", "all done", 64'({mb_ready, mb_abort}), 64'hF0);
    endtask

    task automatic t_tie;
        for (int k = 0; k < 4; k++) load_mb(k, 5, 29'h200 + 29'(k));
        fire(4'hF);
        for (int k = 0; k < 4; k++) begin
            expect_tx(k, 29'h200 + 29'(k), "R3");
            respond(1'b0);
        end
    endtask

    task automatic t_nopreempt;
        load_mb(3, 15, 29'h300);
        fire(4'b1000);
        expect_tx(3, 29'h300, "R5");
        load_mb(0, 0, 29'h301);
        fire(4'b0001);
        repeat (5) @(negedge clk);
        chk(tx_valid && tx_mb == 2'd3 && tx_id == 29'h300, "R5", "held mb3",
            64'({tx_valid, tx_mb}), 64'h7);
        respond(1'b0);
        expect_tx(0, 29'h301, "R5");
        respond(1'b0);
    endtask

    task automatic t_fail;
        load_mb(1, 4, 29'h400);
        fire(4'b0010);
        expect_tx(1, 29'h400, "R7");
        respond(1'b1);
        chk(mb_ready[1] && mb_abort[1], "R7", "mb1 failed", 64'({mb_ready[1], mb_abort[1]}), 64'h3);
        fire(4'b0010);
        chk(!mb_ready[1] && !mb_abort[1], "R4", "resend clears abort",
            64'({mb_ready[1], mb_abort[1]}), 64'h0);
        expect_tx(1, 29'h400, "R4");
        respond(1'b0);
    endtask

    task automatic t_abort;
        load_mb(2, 1, 29'h500); load_mb(0, 2, 29'h501);
        fire(4'b0101);
        expect_tx(2, 29'h500, "R8");
        abort_req = 4'b0101;
        @(negedge clk);
        abort_req = '0;
        chk(mb_ready[0] && mb_abort[0], "R8", "mb0 withdrawn", 64'({mb_ready[0], mb_abort[0]}), 64'h3);
        chk(!mb_ready[2] && !mb_abort[2] && tx_valid && tx_mb == 2'd2, "R8", "mb2 unaffected",
            64'({mb_ready[2], mb_abort[2], tx_valid}), 64'h1);
        respond(1'b0);
        repeat (6) begin
            chk(!tx_valid, "R8", "mb0 never offered", 64'(tx_valid), 64'h0);
            @(negedge clk);
        end
    endtask

    task automatic t_busy_load;
        load_mb(1, 2, 29'h600); load_mb(0, 1, 29'h601);
        fire(4'b0011);
        expect_tx(0, 29'h601, "R9");
        load_mb(1, 0, 29'h6FF);
        fire(4'b0010);
        respond(1'b0);
        expect_tx(1, 29'h600, "R9");
        fire(4'b0010);
        respond(1'b0);
        repeat (5) @(negedge clk);
        chk(!tx_valid && mb_ready[1], "R4", "repeat send ignored",
            64'({tx_valid, mb_ready[1]}), 64'h1);
    endtask

    task automatic t_irq;
        irq_mask = 4'b0101;
        @(negedge clk);
        chk(irq_vec == 4'b0101, "R10", "mask idle", 64'(irq_vec), 64'h5);
        load_mb(0, 3, 29'h700); load_mb(1, 3, 29'h701);
        fire(4'b0011);
        expect_tx(0, 29'h700, "R10");
        chk(irq_vec == 4'b0100, "R10", "mask busy", 64'(irq_vec), 64'h4);
        respond(1'b0);
        expect_tx(1, 29'h701, "R10");
        respond(1'b0);
        chk(irq_vec == 4'b0101, "R10", "mask after", 64'(irq_vec), 64'h5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_prio;
        t_tie;
        t_nopreempt;
        t_fail;
        t_abort;
        t_busy_load;
        t_irq;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule